// File: doc/BRIEF.md
# Two-Channel Interrupt Gate and DMA Routing Register Block

This block sits on a byte-wide register bus of a disk interface card that carries two drive channels. Each channel has a raw interrupt request line from its drive. The block keeps a per-channel enable bit and passes a request on only while that bit is set. It merges the passed requests into one interrupt output for the host, and it offers a status location per channel where software can see the raw request, whether or not it is enabled.

The enable bits respond to the type of bus access, and the data byte plays no part. A write to a channel's gate location arms that channel. A read of the same location disarms it, as a side effect of the read.

A routing register chooses which channel receives the card's single DMA request and acknowledge pair. The same register holds a flag that opens an extended address window. Writing zero to it closes the window and returns the card to its power-on view.

Top module: `chan_irq_route_regs`

## Requirements
- R1: Any write to a channel's gate location (channel 0 at 0x2200, channel 1 at 0x3200) sets that channel's enable from the next clock, whatever the data byte holds.
- R2: A read of a channel's gate location clears that channel's enable from the next clock and returns 0x00.
- R3: When read and write strobes both hit a gate location in the same cycle, the write wins and the enable ends up set.
- R4: A read of a channel's status location (gate location plus 0x90) returns that channel's raw request in bit 0 and zero in bits 7..1, regardless of the enable. The read leaves both enables unchanged.
- R5: The combined interrupt output is high exactly when at least one channel has both its raw request and its enable high. It follows the raw inputs without a register stage.
- R6: The routing register at offset 0x0000 keeps only bit 0 (channel select: 0 = channel 0, 1 = channel 1) and bit 5 (extended window enable). Both appear on their output pins from the next clock. A read returns the kept bits with the others at zero, and a write of 0x00 clears both.
- R7: The shared DMA request output equals the request of the selected channel. The shared acknowledge input drives only the selected channel's acknowledge output, and the other channel's acknowledge stays low.
- R8: Reads of unmapped offsets return 0x00. Reads and writes of unmapped offsets change neither the enables nor the routing register.
- R9: After reset both enables and the routing register are zero.
- R10: Read data is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| chan_irq_raw | input | 2 | Raw interrupt request per channel |
| irq_out | output | 1 | Combined gated interrupt |
| ch_dreq | input | 2 | DMA request per channel |
| dma_req | output | 1 | Shared DMA request toward the DMA engine |
| dma_ack | input | 1 | Shared DMA acknowledge from the DMA engine |
| ch_dack | output | 2 | DMA acknowledge per channel |
| dma_sel | output | 1 | Current channel select |
| ext_win_en | output | 1 | Extended address window enable |

## Verification
The bench sweeps every pairing of enable state and raw request level. Each pairing is checked through the combined output and through the status reads. A design that gated the status bit with the enable, or that let a status read disturb the enables, shows a mismatch there. Every write byte of the routing register is tried, which catches a design that keeps stray bits or shifts the window flag. Gate writes use changing data bytes, including 0x00, which catches a design that takes the enable from a data bit. A read and a write that hit the gate location together must leave the channel armed. A run of unmapped reads and writes must leave both enables and the routing state as they were, and this is checked one channel at a time.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

   // Byte offset of a channel's register group
   function automatic int unsigned chan_offset(input int unsigned base,
                                               input int unsigned stride,
                                               input int unsigned idx);
      return base + idx * stride;
   endfunction

   // Width of a channel select field for a channel count
   function automatic int unsigned sel_width(input int unsigned nch);
      return (nch < 2) ? 1 : $clog2(nch);
   endfunction

endpackage

// File: rtl/irq_gate_ch.sv
module irq_gate_ch #(
   parameter int unsigned        ADDR_W    = 14,
   parameter int unsigned        DATA_W    = 8,
   parameter logic [ADDR_W-1:0]  GATE_ADDR = '0,
   parameter logic [ADDR_W-1:0]  STAT_ADDR = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              raw_req,
   output logic              gated_req,
   output logic              hit_any,
   output logic [DATA_W-1:0] stat_rd
);

   logic gate_hit;
   logic stat_hit;
   logic en_q;

   assign gate_hit = (addr == GATE_ADDR);
   assign stat_hit = (addr == STAT_ADDR);
   assign hit_any  = gate_hit | stat_hit;

   // Access type alone drives the enable; write has priority
   always_ff @(posedge clk) begin
      if (!rst_n)              en_q <= 1'b0;
      else if (wr && gate_hit) en_q <= 1'b1;
      else if (rd && gate_hit) en_q <= 1'b0;
   end

   assign gated_req = raw_req & en_q;
   assign stat_rd   = stat_hit ? {{(DATA_W-1){1'b0}}, raw_req} : '0;

   // R1
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && gate_hit) |=> en_q);

   // R2
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && gate_hit) |=> !en_q);

   // R8
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((rd || wr) && gate_hit) |=> $stable(en_q));

endmodule

// File: rtl/route_sel_reg.sv
module route_sel_reg #(
   parameter int unsigned        ADDR_W     = 14,
   parameter int unsigned        DATA_W     = 8,
   parameter logic [ADDR_W-1:0]  ROUTE_ADDR = '0,
   parameter int unsigned        SEL_W      = 1,
   parameter int unsigned        WIN_BIT    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              hit,
   output logic [SEL_W-1:0]  sel,
   output logic              win_en,
   output logic [DATA_W-1:0] rd_val
);

   localparam logic [DATA_W-1:0] SEL_MASK  = DATA_W'((1 << SEL_W) - 1);
   localparam logic [DATA_W-1:0] WIN_MASK  = DATA_W'(1) << WIN_BIT;
   localparam logic [DATA_W-1:0] KEEP_MASK = SEL_MASK | WIN_MASK;

   logic [DATA_W-1:0] reg_q;

   assign hit = (addr == ROUTE_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)         reg_q <= '0;
      else if (wr && hit) reg_q <= wdata & KEEP_MASK;
   end

   assign sel    = reg_q[SEL_W-1:0];
   assign win_en = reg_q[WIN_BIT];
   assign rd_val = reg_q;

   // R6
   route_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit) |=> (sel == $past(wdata[SEL_W-1:0]) && win_en == $past(wdata[WIN_BIT])));

   // R8
   route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && hit) |=> $stable(rd_val));

endmodule

// File: rtl/dma_router.sv
module dma_router #(
   parameter int unsigned N_CH  = 2,
   parameter int unsigned SEL_W = 1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [N_CH-1:0]  ch_dreq,
   input  logic             dma_ack,
   output logic             dma_req,
   output logic [N_CH-1:0]  ch_dack
);

   logic [N_CH-1:0] sel_mask;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      assign sel_mask[k] = (sel == SEL_W'(k));
      assign ch_dack[k]  = dma_ack & sel_mask[k];
   end

   assign dma_req = |(ch_dreq & sel_mask);

endmodule

// File: rtl/chan_irq_route_regs.sv
module chan_irq_route_regs
   import cirq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned N_CH       = 2,
   parameter int unsigned GATE_BASE  = 'h2200,
   parameter int unsigned CH_STRIDE  = 'h1000,
   parameter int unsigned STAT_OFS   = 'h0090,
   parameter int unsigned ROUTE_ADDR = 'h0000,
   parameter int unsigned WIN_BIT    = 5,
   localparam int unsigned SEL_W     = sel_width(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_CH-1:0]   chan_irq_raw,
   output logic              irq_out,
   input  logic [N_CH-1:0]   ch_dreq,
   output logic              dma_req,
   input  logic              dma_ack,
   output logic [N_CH-1:0]   ch_dack,
   output logic [SEL_W-1:0]  dma_sel,
   output logic              ext_win_en
);

   // Elaboration-time configuration checks
   if (N_CH < 2) begin : g_bad_nch
      $error("chan_irq_route_regs: N_CH must be at least 2");
   end
   if (DATA_W < 2 || WIN_BIT >= DATA_W || WIN_BIT < SEL_W) begin : g_bad_win
      $error("chan_irq_route_regs: WIN_BIT must lie above the select field and inside the data byte");
   end
   if (STAT_OFS == 0 || STAT_OFS >= CH_STRIDE) begin : g_bad_stat
      $error("chan_irq_route_regs: STAT_OFS must be nonzero and below CH_STRIDE");
   end
   if (chan_offset(GATE_BASE, CH_STRIDE, N_CH - 1) + STAT_OFS >= (1 << ADDR_W)) begin : g_bad_span
      $error("chan_irq_route_regs: channel groups exceed the address range");
   end

   logic [N_CH-1:0]             gated;
   logic [N_CH-1:0]             ch_hit;
   logic [N_CH-1:0][DATA_W-1:0] stat_rd;
   logic                        route_hit;
   logic [DATA_W-1:0]           route_val;
   logic [DATA_W-1:0]           stat_or;

   for (genvar k = 0; k < N_CH; k++) begin : g_gate
      localparam logic [ADDR_W-1:0] GA = ADDR_W'(chan_offset(GATE_BASE, CH_STRIDE, k));
      localparam logic [ADDR_W-1:0] SA = ADDR_W'(chan_offset(GATE_BASE, CH_STRIDE, k) + STAT_OFS);

      irq_gate_ch #(
         .ADDR_W    (ADDR_W),
         .DATA_W    (DATA_W),
         .GATE_ADDR (GA),
         .STAT_ADDR (SA)
      ) u_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .addr      (bus_addr),
         .rd        (bus_rd),
         .wr        (bus_wr),
         .raw_req   (chan_irq_raw[k]),
         .gated_req (gated[k]),
         .hit_any   (ch_hit[k]),
         .stat_rd   (stat_rd[k])
      );
   end

   route_sel_reg #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ROUTE_ADDR (ADDR_W'(ROUTE_ADDR)),
      .SEL_W      (SEL_W),
      .WIN_BIT    (WIN_BIT)
   ) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .hit    (route_hit),
      .sel    (dma_sel),
      .win_en (ext_win_en),
      .rd_val (route_val)
   );

   dma_router #(
      .N_CH  (N_CH),
      .SEL_W (SEL_W)
   ) u_dma (
      .sel     (dma_sel),
      .ch_dreq (ch_dreq),
      .dma_ack (dma_ack),
      .dma_req (dma_req),
      .ch_dack (ch_dack)
   );

   assign irq_out = |gated;

   // Decodes are mutually exclusive, so the sources are simply OR-ed
   always_comb begin
      stat_or = '0;
      for (int k = 0; k < N_CH; k++) stat_or |= stat_rd[k];
   end

   assign bus_rdata = bus_rd ? (stat_or | (route_hit ? route_val : '0)) : '0;

   // R7
   dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_dack));

   // R8
   decode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_hit, route_hit}));

   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/chan_irq_route_regs_bench.sv
`timescale 1ns/1ps
module chan_irq_route_regs_bench;

   localparam int CLK_HALF = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  chan_irq_raw = '0;
   logic        irq_out;
   logic [1:0]  ch_dreq = '0;
   logic        dma_req;
   logic        dma_ack = 1'b0;
   logic [1:0]  ch_dack;
   logic [0:0]  dma_sel;
   logic        ext_win_en;

   int n_chk = 0;
   int n_bad = 0;

   always #CLK_HALF clk = ~clk;

   chan_irq_route_regs u_chan_irq_route_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_rd       (bus_rd),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .chan_irq_raw (chan_irq_raw),
      .irq_out      (irq_out),
      .ch_dreq      (ch_dreq),
      .dma_req      (dma_req),
      .dma_ack      (dma_ack),
      .ch_dack      (ch_dack),
      .dma_sel      (dma_sel),
      .ext_win_en   (ext_win_en)
   );

   function automatic logic [13:0] gate_of(input int ch);
      return 14'(32'h2200 + ch * 32'h1000);
   endfunction

   function automatic logic [13:0] stat_of(input int ch);
      return 14'(32'h2290 + ch * 32'h1000);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [13:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_rdwr(input logic [13:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   // Checks the enable of one channel through irq_out with only its raw line high
   task automatic probe_en(input string req, input int ch, input logic exp_en);
      chan_irq_raw = 2'b01 << ch;
      #1 chk(req, {7'b0, irq_out}, {7'b0, exp_en});
   endtask

   initial begin
      #(2 * CLK_HALF * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      chan_irq_raw = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      #1 chk("R9 irq", {7'b0, irq_out}, 8'h00);
      chk("R9 sel", {7'b0, dma_sel}, 8'h00);
      chk("R9 win", {7'b0, ext_win_en}, 8'h00);
      bus_read(14'h0000, rd);
      chk("R9 route", rd, 8'h00);

      // R1 R2 R4 R5: every enable pattern against every raw pattern
      for (int ep = 0; ep < 4; ep++) begin
         for (int rp = 0; rp < 4; rp++) begin
            for (int ch = 0; ch < 2; ch++) begin
               if (ep[ch]) bus_write(gate_of(ch), 8'((ep * 4 + rp) * 37 + ch * 128));
               else begin
                  bus_read(gate_of(ch), rd);
                  chk("R2 gate read", rd, 8'h00);
               end
            end
            chan_irq_raw = 2'(rp);
            #1 chk("R5 combine", {7'b0, irq_out}, {7'b0, |(2'(ep) & 2'(rp))});
            for (int ch = 0; ch < 2; ch++) begin
               bus_read(stat_of(ch), rd);
               chk("R4 status", rd, {7'b0, rp[ch]});
            end
            #1 chk("R4 no side effect", {7'b0, irq_out}, {7'b0, |(2'(ep) & 2'(rp))});
            for (int ch = 0; ch < 2; ch++) probe_en("R1 R2 enable", ch, ep[ch]);
         end
      end

      // R1: a zero data byte still arms
      bus_read(gate_of(0), rd);
      bus_read(gate_of(1), rd);
      bus_write(gate_of(1), 8'h00);
      probe_en("R1 zero data", 1, 1'b1);
      probe_en("R1 other untouched", 0, 1'b0);

      // R3: simultaneous read and write arms
      bus_rdwr(gate_of(0));
      probe_en("R3 write wins", 0, 1'b1);

      // R8: unmapped reads and writes leave state alone
      begin
         logic [13:0] um [8];
         um = '{14'h0001, 14'h0021, 14'h2201, 14'h2291, 14'h2280,
                14'h3201, 14'h3291, 14'h3FFF};
         foreach (um[i]) begin
            bus_read(um[i], rd);
            chk("R8 unmapped read", rd, 8'h00);
            bus_write(um[i], 8'hFF);
         end
      end
      probe_en("R8 enable ch0 kept", 0, 1'b1);
      probe_en("R8 enable ch1 kept", 1, 1'b1);
      #1 chk("R8 sel kept", {7'b0, dma_sel}, 8'h00);
      chk("R8 win kept", {7'b0, ext_win_en}, 8'h00);

      // R6: every write byte of the routing register
      for (int d = 0; d < 256; d++) begin
         bus_write(14'h0000, 8'(d));
         chk("R6 sel pin", {7'b0, dma_sel}, {7'b0, d[0]});
         chk("R6 win pin", {7'b0, ext_win_en}, {7'b0, d[5]});
         bus_read(14'h0000, rd);
         chk("R6 readback", rd, 8'(d) & 8'h21);
      end

      // R7: DMA routing for each select
      for (int s = 0; s < 2; s++) begin
         bus_write(14'h0000, 8'(s) | 8'h20);
         for (int dr = 0; dr < 4; dr++) begin
            for (int ak = 0; ak < 2; ak++) begin
               ch_dreq = 2'(dr); dma_ack = ak[0];
               #1 chk("R7 req", {7'b0, dma_req}, {7'b0, dr[s]});
               chk("R7 ack", {6'b0, ch_dack}, ak[0] ? 8'(1 << s) : 8'h00);
            end
         end
      end

      // R6: writing zero closes the window
      bus_write(14'h0000, 8'h00);
      chk("R6 zero win", {7'b0, ext_win_en}, 8'h00);
      chk("R6 zero sel", {7'b0, dma_sel}, 8'h00);

      // R10: no read strobe, no data
      @(negedge clk);
      chan_irq_raw = 2'b11; bus_addr = stat_of(0);
      #1 chk("R10 idle rdata", bus_rdata, 8'h00);
      bus_addr = 14'h0000;
      #1 chk("R10 idle route", bus_rdata, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule